// File: doc/BRIEF.md
# Share-Counted Round-Robin Arbiter

This block chooses which of several memory-mapped masters may drive one shared slave port, for example the port of a DRAM controller. A master does not lose the grant after every access. Each master carries its own share: the number of accepted transactions it may chain back to back before the grant rotates. The default share is one, which gives strict alternation. A share of eight lets a cache-line fill of eight 32-bit words run without interruption.

Each master raises a request line and holds it until it has nothing more to issue. The slave side reports each accepted transaction with a one-cycle strobe. This is the cycle where the granted master's access is presented and the slave's wait signal is low. The arbiter replies with a registered one-hot grant, a grant-valid flag, and a binary select index for the address and data multiplexer.

The block is control only. Nothing flows through it, so there is no valid/ready handshake. Back-pressure reaches the arbiter only through the accept strobe: while the slave stalls, the strobe stays low and the grant is frozen.

Top module: `share_rr_arbiter`

## Requirements
- R1: While reset is held and right after it, `grant` is all zero, `grant_valid` is 0 and `sel` is 0.
- R2: `grant` has at most one bit set. `grant_valid` is 1 exactly when a bit is set, and `sel` is the binary index of that bit (bit i of `grant` belongs to master i).
- R3: When nobody holds the grant, requests sampled at a clock edge produce a grant after that edge. The grant goes to the first requesting master after the round-robin pointer in circular order of increasing index. The pointer starts at the last index after reset, so master 0 is searched first.
- R4: A master with share S keeps the grant for S accepted transactions while it requests. After the S-th accept, the grant passes to the first requester after it in circular order. If that master is the only requester, it keeps the grant with a fresh share.
- R5: Only cycles with `accept` high use up share. Any number of stalled cycles with `accept` low leave the grant and the remaining share unchanged.
- R6: If the granted master lowers its request before its share is spent, the grant moves at the next edge to the first other requester after it, or to nobody.
- R7: With no request pending, no master is granted and the pointer keeps the index of the last granted master. The next grant then searches from the master after that one.
- R8: While the granted master requests, the grant changes only at an edge where `accept` is high. It never changes during a stalled transfer.
- R9: A master with the default share of 1 loses the grant after every accepted transaction when another master is requesting.
- R10: A share of 8 is supported: such a master completes eight consecutive accepted transactions before rotation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | N_MASTERS | Request per master, held until the master is finished |
| accept | input | 1 | Slave accepted the granted master's transaction this cycle |
| grant | output | N_MASTERS | One-hot grant, registered |
| grant_valid | output | 1 | Some master holds the grant |
| sel | output | IDX_W | Binary index of the granted master, 0 when idle |

## Verification
Every output is registered. A request or accept pattern present at a rising edge shows up in `grant`, `grant_valid` and `sel` just after that edge, with exactly one cycle of latency. The bench changes inputs on the falling edge and reads outputs 1 ns after the following rising edge, so each check sees the response to exactly one sampled pattern. Share counting is checked accept by accept, with stall cycles placed between accepts. Early release, idling and the pointer kept across idle time each have their own directed scenario.

// File: rtl/share_arb_pkg.sv
package share_arb_pkg;
  // circular successor: index reached k steps after base among n entries
  function automatic int circ_step(input int base, input int k, input int n);
    return (base + k) % n;
  endfunction
endpackage

// File: rtl/rr_pick.sv
module rr_pick import share_arb_pkg::*; #(
  parameter int N     = 4,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  input  logic [IDX_W-1:0] base,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  // search base+1, base+2, ... base+N; base itself is tried last
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = 1; k <= N; k++) begin
      int j;
      j = circ_step(int'(base), k, N);
      if (!found && req[j]) begin
        found = 1'b1;
        idx   = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/share_counter.sv
module share_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - 1'b1;
  end

  assign last = (cnt == CNT_W'(1));

  // R5: share is only spent on accepted transactions, never below zero
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |-> (cnt != '0));
  p_stall_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec && !load) |=> $stable(cnt));
endmodule

// File: rtl/grant_encode.sv
module grant_encode #(
  parameter int N     = 4,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             valid,
  input  logic [IDX_W-1:0] idx,
  output logic [N-1:0]     onehot
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign onehot[i] = valid && (idx == IDX_W'(i));
  end
endmodule

// File: rtl/share_rr_arbiter.sv
module share_rr_arbiter #(
  parameter int N_MASTERS = 4,
  parameter int CNT_W     = 4,
  // share of master i in bits [i*CNT_W +: CNT_W], each 1 .. 2**CNT_W-1
  parameter logic [N_MASTERS*CNT_W-1:0] SHARES = {4'd1, 4'd2, 4'd1, 4'd8},
  localparam int IDX_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] req,
  input  logic                 accept,
  output logic [N_MASTERS-1:0] grant,
  output logic                 grant_valid,
  output logic [IDX_W-1:0]     sel
);
  logic             own_v;
  logic [IDX_W-1:0] own_idx;
  logic [IDX_W-1:0] ptr;
  logic             pick_found;
  logic [IDX_W-1:0] pick_idx;
  logic             share_last;
  logic             switch_now;
  logic             owner_req;
  logic [CNT_W-1:0] share_new;

  rr_pick #(.N(N_MASTERS), .IDX_W(IDX_W)) u_pick (
    .req(req), .base(ptr), .found(pick_found), .idx(pick_idx)
  );

  assign owner_req  = req[own_idx];
  assign switch_now = !own_v || !owner_req || (accept && share_last);
  assign share_new  = SHARES[int'(pick_idx)*CNT_W +: CNT_W];

  share_counter #(.CNT_W(CNT_W)) u_share (
    .clk(clk), .rst_n(rst_n),
    .load(switch_now && pick_found),
    .load_val(share_new),
    .dec(accept && own_v && !switch_now),
    .last(share_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_v   <= 1'b0;
      own_idx <= '0;
      ptr     <= IDX_W'(N_MASTERS - 1);
    end else if (switch_now) begin
      own_v <= pick_found;
      if (pick_found) begin
        own_idx <= pick_idx;
        ptr     <= pick_idx;
      end
    end
  end

  grant_encode #(.N(N_MASTERS), .IDX_W(IDX_W)) u_enc (
    .valid(own_v), .idx(own_idx), .onehot(grant)
  );

  assign grant_valid = own_v;
  assign sel         = own_v ? own_idx : '0;

  // R2: at most one grant, flag and index agree with it
  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  p_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid == (grant != '0));
  p_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> grant[sel]);
  // R8: no movement during a stalled transfer of a still-requesting owner
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && req[sel] && !accept) |=> $stable(grant));
  // R7: nothing requested -> nothing granted at the next edge
  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |=> (grant == '0));
  // R3: an idle arbiter with a request grants at the next edge
  p_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_valid && req != '0) |=> grant_valid);
endmodule

// File: tb/sim_share_rr_arbiter.sv
`timescale 1ns/1ps
module sim_share_rr_arbiter;
  localparam int N = 4;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic         accept = 1'b0;
  logic [N-1:0] grant;
  logic         grant_valid;
  logic [1:0]   sel;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // shares used below: m0=8, m1=1, m2=2, m3=1 (module defaults)
  share_rr_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .accept(accept),
    .grant(grant), .grant_valid(grant_valid), .sel(sel)
  );

  task automatic chk(input string r, input logic [N-1:0] exp_g);
    logic [1:0] exp_s;
    exp_s = 2'd0;
    for (int i = 0; i < N; i++) if (exp_g[i]) exp_s = 2'(i);
    n_chk++;
    if (grant !== exp_g || grant_valid !== (exp_g != '0) || sel !== exp_s) begin
      n_err++;
      $display("FAIL %s: grant=%b valid=%b sel=%0d expected grant=%b valid=%b sel=%0d",
               r, grant, grant_valid, sel, exp_g, (exp_g != '0), exp_s);
    end
  endtask

  task automatic cyc(input logic [N-1:0] r, input logic a);
    @(negedge clk);
    req = r;
    accept = a;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    #1 chk("R1 during reset", 4'b0000);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 after reset", 4'b0000);
  endtask

  task automatic t_rotate_unit_share;
    cyc(4'b1010, 1'b0); chk("R3 first requester after pointer", 4'b0010);
    cyc(4'b1010, 1'b1); chk("R9 share 1 rotates to m3", 4'b1000);
    for (int i = 0; i < 3; i++) begin
      cyc(4'b1010, 1'b0); chk("R5 stall holds m3", 4'b1000);
    end
    cyc(4'b1010, 1'b1); chk("R9 wrap back to m1", 4'b0010);
  endtask

  task automatic t_idle_pointer;
    cyc(4'b0000, 1'b0); chk("R7 idle after release", 4'b0000);
    cyc(4'b0000, 1'b0); chk("R7 stays idle", 4'b0000);
    cyc(4'b1011, 1'b0); chk("R7 search resumes after m1", 4'b1000);
    cyc(4'b0000, 1'b0); chk("R7 idle again", 4'b0000);
  endtask

  task automatic t_share_eight;
    cyc(4'b0101, 1'b0); chk("R3 m0 after pointer m3", 4'b0001);
    for (int i = 1; i <= 7; i++) begin
      cyc(4'b0101, 1'b1); chk("R10 m0 keeps grant within share", 4'b0001);
      if (i == 4) begin
        cyc(4'b0101, 1'b0); chk("R8 stall mid share", 4'b0001);
      end
    end
    cyc(4'b0101, 1'b1); chk("R4 eighth accept rotates to m2", 4'b0100);
    cyc(4'b0101, 1'b1); chk("R4 m2 share 2 holds", 4'b0100);
    cyc(4'b0101, 1'b1); chk("R4 m2 share spent to m0", 4'b0001);
  endtask

  task automatic t_early_release;
    cyc(4'b0101, 1'b1); chk("R4 m0 holds", 4'b0001);
    cyc(4'b0101, 1'b1); chk("R4 m0 holds", 4'b0001);
    cyc(4'b0100, 1'b0); chk("R6 early release to m2", 4'b0100);
  endtask

  task automatic t_sole_requester;
    cyc(4'b0100, 1'b1); chk("R4 sole m2 first accept", 4'b0100);
    cyc(4'b0100, 1'b1); chk("R4 sole m2 reloads", 4'b0100);
    cyc(4'b0100, 1'b1); chk("R4 sole m2 continues", 4'b0100);
    cyc(4'b0000, 1'b0); chk("R6 release to nobody", 4'b0000);
  endtask

  initial begin
    t_reset();
    t_rotate_unit_share();
    t_idle_pointer();
    t_share_eight();
    t_early_release();
    t_sole_requester();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule